// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control and status words reached through a plain single-cycle register bus: a byte address, a write strobe with write data, and a read strobe whose data comes back one clock later. The address decodes a 4 KiB window. Only the lower part of that window is backed by storage. Accesses above the backed part are accepted without error: writes there are discarded and reads there return zero.

One fixed location in the unbacked upper part works as a command port. Writing the code 1 or 2 there asks the system to reset. Writing the code 3 there asks it to shut down. Each request is a registered pulse one clock wide. Three read locations report their stored word with two status bits always shown as set. Four identification words take fixed values at reset, and every other backed word clears to zero.

Top module: `sysctl_regs`

## Requirements
- R1: The byte address is split into a word index equal to address bits [11:2]. Address bits [1:0] do not affect which word is accessed.
- R2: A write with a word index below 0x200 is stored on the clock edge that samples the write strobe. A read of that word issued on any later cycle returns the stored value.
- R3: A write with a word index of 0x200 or higher changes no stored word.
- R4: A read with a word index of 0x200 or higher returns 0x00000000.
- R5: A write to byte offset 0xF00 with data 1 or 2 drives `sys_reset_req` high for exactly the one cycle after the write, and nothing is stored.
- R6: A write to byte offset 0xF00 with data 3 drives `sys_shutdown_req` high for exactly the one cycle after the write. Any other data value, and any write to another offset, raises neither request. Both requests are never high together.
- R7: A read at byte offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000, which sets bits 29 and 28. A read at any other offset returns the word unmodified.
- R8: After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. All other backed words hold zero.
- R9: `bus_rdata` is registered. It updates one cycle after a cycle with `bus_rd_en` high and keeps its value while `bus_rd_en` is low. It is zero after reset. A read in the same cycle as a write to the same word returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system-reset request |
| sys_shutdown_req | output | 1 | One-cycle system-shutdown request |

## Verification
The bench builds the block with its default parameters: a 12-bit address and 512 backed words. At that size every one of the 1024 word offsets in the window can be swept. After reset, every offset is read and compared with an arithmetic model of the identification values, the forced status bits and the zero region. A second pass writes a position-dependent pattern to every offset, then reads all of them back. This shows that the backed words store correctly and that the upper words neither store nor alias onto lower ones. Command codes 0 through 5, together with writes to offsets next to the command port, exercise the pulse width, the code decoding and the stored contents.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int unsigned DATA_W = 32;

    // Word index of the command port (byte offset 0xF00)
    localparam logic [9:0] CMD_WORD = 10'h3C0;

    // Word indices whose read data shows forced status bits
    localparam logic [9:0] STAT_WORD_A = 10'h040;
    localparam logic [9:0] STAT_WORD_B = 10'h042;
    localparam logic [9:0] STAT_WORD_C = 10'h043;
    localparam logic [DATA_W-1:0] STAT_MASK = 32'h3000_0000;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_RESET    = 2'd1,
        CMD_SHUTDOWN = 2'd2
    } cmd_e;

    function automatic logic [DATA_W-1:0] reset_word(input int unsigned idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return '0;
        endcase
    endfunction

    function automatic cmd_e decode_cmd(input logic [DATA_W-1:0] val);
        if (val == 32'd1 || val == 32'd2) return CMD_RESET;
        if (val == 32'd3)                 return CMD_SHUTDOWN;
        return CMD_NONE;
    endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 512,
    localparam int unsigned IDX_W = ADDR_W - 2,
    localparam int unsigned MEM_AW = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]  word_idx,
    output logic [MEM_AW-1:0] mem_idx,
    output logic              in_range,
    output logic              is_cmd,
    output logic              force_stat
);
    import sysctl_pkg::*;

    always_comb begin
        mem_idx    = word_idx[MEM_AW-1:0];
        in_range   = (32'(word_idx) < DEPTH);
        is_cmd     = (word_idx == IDX_W'(CMD_WORD));
        force_stat = (word_idx == IDX_W'(STAT_WORD_A)) ||
                     (word_idx == IDX_W'(STAT_WORD_B)) ||
                     (word_idx == IDX_W'(STAT_WORD_C));
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned MEM_AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [MEM_AW-1:0] idx,
    input  logic              in_range,
    input  logic              force_stat,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    import sysctl_pkg::*;

    logic [31:0] mem_d [DEPTH];
    logic [31:0] mem_q [DEPTH];
    logic [31:0] rdata_d, rdata_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        rdata_d = rdata_q;
        if (wr_en && in_range) mem_d[idx] = wdata;
        if (rd_en) begin
            rdata_d = in_range ? mem_q[idx] : '0;
            if (force_stat) rdata_d = rdata_d | STAT_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= reset_word(i);
            rdata_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R9
    hold_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata_q));

    // R4
    oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && !$past(in_range)) |-> (rdata_q == 32'd0));
endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        is_cmd,
    input  logic [31:0] wdata,
    output logic        reset_req,
    output logic        shutdown_req
);
    import sysctl_pkg::*;

    typedef struct packed {
        logic rst;
        logic shut;
    } req_t;

    req_t req_d, req_q;
    cmd_e code;

    always_comb begin
        code   = decode_cmd(wdata);
        req_d  = '0;
        if (wr_en && is_cmd) begin
            req_d.rst  = (code == CMD_RESET);
            req_d.shut = (code == CMD_SHUTDOWN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign reset_req    = req_q.rst;
    assign shutdown_req = req_q.shut;

    // R6
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_q.rst, req_q.shut}));

    // R5
    rst_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_q.rst |-> ($past(wr_en) && $past(is_cmd)));

    // R6
    shut_from_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(is_cmd) && $past(wdata) == 32'd3) |-> req_q.shut);

    // R5
    rst_from_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(is_cmd) && ($past(wdata) == 32'd1 || $past(wdata) == 32'd2))
        |-> req_q.rst);
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd_en,
    output logic [31:0]       bus_rdata,
    output logic              sys_reset_req,
    output logic              sys_shutdown_req
);
    localparam int unsigned IDX_W  = ADDR_W - 2;
    localparam int unsigned MEM_AW = $clog2(DEPTH);

    logic [IDX_W-1:0]  word_idx;
    logic [MEM_AW-1:0] mem_idx;
    logic              in_range, is_cmd, force_stat;

    // R1: byte lanes are not decoded
    assign word_idx = bus_addr[ADDR_W-1:2];

    sysctl_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_decode (
        .word_idx   (word_idx),
        .mem_idx    (mem_idx),
        .in_range   (in_range),
        .is_cmd     (is_cmd),
        .force_stat (force_stat)
    );

    sysctl_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr_en),
        .rd_en      (bus_rd_en),
        .idx        (mem_idx),
        .in_range   (in_range),
        .force_stat (force_stat),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata)
    );

    sysctl_cmd u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_wr_en),
        .is_cmd       (is_cmd),
        .wdata        (bus_wdata),
        .reset_req    (sys_reset_req),
        .shutdown_req (sys_shutdown_req)
    );

    // R5
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req || $past(bus_wr_en));
endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr_en = 0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 0;
    logic [31:0] bus_rdata;
    logic        sys_reset_req, sys_shutdown_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sysctl_regs u_dut (.*);

    function automatic logic [31:0] pat(input int i);
        return (i * 32'h9E37_79B1) ^ 32'h5A00_00A5;
    endfunction

    function automatic logic [31:0] stat_or(input int i);
        return (i == 'h40 || i == 'h42 || i == 'h43) ? 32'h3000_0000 : 32'h0;
    endfunction

    function automatic logic [31:0] rst_val(input int i);
        case (i)
            'h40: return 32'h05F2_0121;
            'h41: return 32'h0000_0002;
            'h42: return 32'h05F3_0121;
            'h43: return 32'h05F4_0121;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1;
        @(negedge clk);
        bus_wr_en = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1;
        @(negedge clk);
        bus_rd_en = 0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R9 reset rdata", bus_rdata, 32'h0);
        chk("R5 reset req", {31'b0, sys_reset_req}, 32'h0);
        chk("R6 shutdown req", {31'b0, sys_shutdown_req}, 32'h0);

        // R8 / R7 / R4: sweep every word after reset
        for (int i = 0; i < 1024; i++) begin
            rd(12'(i * 4), d);
            chk(i < 512 ? "R8 reset sweep" : "R4 oob read", d,
                (i < 512 ? rst_val(i) : 32'h0) | stat_or(i));
        end

        // R2 / R3: write pattern everywhere except the command port
        for (int i = 0; i < 1024; i++)
            if (i != 'h3C0) wr(12'(i * 4), pat(i));
        for (int i = 0; i < 1024; i++) begin
            rd(12'(i * 4), d);
            chk(i < 512 ? "R2 R3 readback" : "R4 oob after write", d,
                (i < 512 ? pat(i) : 32'h0) | stat_or(i));
        end

        // R1: low address bits ignored
        wr(12'h0A7, 32'hCAFE_0001);
        rd(12'h0A4, d); chk("R1 low bits write", d, 32'hCAFE_0001);
        rd(12'h0A6, d); chk("R1 low bits read", d, 32'hCAFE_0001);

        // R7: stored value keeps bits clear, forced only on status words
        wr(12'h100, 32'h0); rd(12'h100, d); chk("R7 forced 0x100", d, 32'h3000_0000);
        wr(12'h104, 32'h0); rd(12'h104, d); chk("R7 unforced 0x104", d, 32'h0);
        wr(12'h10C, 32'h0000_00FF); rd(12'h10D, d); chk("R7 forced 0x10C", d, 32'h3000_00FF);

        // R9: rdata holds while rd_en low
        rd(12'h0A4, d);
        repeat (3) @(negedge clk);
        chk("R9 hold", bus_rdata, 32'hCAFE_0001);

        // R9: read-during-write returns old value
        @(negedge clk);
        bus_addr = 12'h0A4; bus_wdata = 32'h1234_5678; bus_wr_en = 1; bus_rd_en = 1;
        @(negedge clk);
        bus_wr_en = 0; bus_rd_en = 0;
        chk("R9 old on collision", bus_rdata, 32'hCAFE_0001);
        rd(12'h0A4, d); chk("R2 new after collision", d, 32'h1234_5678);

        // R5 / R6: command codes 0..5
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            bus_addr = 12'hF00; bus_wdata = v; bus_wr_en = 1;
            @(negedge clk);
            bus_wr_en = 0;
            chk("R5 reset pulse", {31'b0, sys_reset_req}, (v == 1 || v == 2) ? 1 : 0);
            chk("R6 shutdown pulse", {31'b0, sys_shutdown_req}, (v == 3) ? 1 : 0);
            @(negedge clk);
            chk("R5 pulse width", {31'b0, sys_reset_req}, 32'h0);
            chk("R6 pulse width", {31'b0, sys_shutdown_req}, 32'h0);
        end

        // R6: neighbouring offsets raise nothing
        @(negedge clk);
        bus_addr = 12'hF04; bus_wdata = 32'd1; bus_wr_en = 1;
        @(negedge clk);
        bus_wr_en = 0;
        chk("R6 no req at 0xF04", {30'b0, sys_reset_req, sys_shutdown_req}, 32'h0);
        @(negedge clk);
        bus_addr = 12'h300; bus_wdata = 32'd3; bus_wr_en = 1;
        @(negedge clk);
        bus_wr_en = 0;
        chk("R6 no req at 0x300", {30'b0, sys_reset_req, sys_shutdown_req}, 32'h0);

        // R5: command write not stored, no alias onto word 0x1C0
        rd(12'hF00, d); chk("R5 cmd not stored", d, 32'h0);
        rd(12'h700, d); chk("R3 no alias of cmd", d, pat('h1C0));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule